// File: doc/BRIEF.md
# Configurable Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of 2^IDX_W prediction entries and a global shift register with the outcomes of the most recent resolved branches. A static two-bit mode input selects how a table slot is chosen. The slot can come from the branch address alone, from the history alone, from the history XORed with the address, or from history bits placed above address bits.

The fetch stage presents a branch address on the lookup port and gets a taken/not-taken guess back combinationally in the same cycle. Later, the execute stage presents the branch address and its resolved direction on the update port. That trains the selected entry and shifts the outcome into the history. A generate choice builds each entry either as a single last-outcome bit or as a saturating counter of CTR_W bits.

Top module: `bpred_top`

## Requirements
- R1: The table has 2^IDX_W entries. The lookup output is a combinational function of the lookup address, the mode and the current state, and it is valid in the same cycle.
- R2: With mode 0 (address mode), the slot is branch address bits [IDX_W+1:2]. Two addresses that agree in those bits share one entry.
- R3: With mode 1 (history-only mode), the slot is the history register value, and the address has no effect.
- R4: With mode 2 (hashed mode), the slot is the history register XORed with address bits [IDX_W+1:2].
- R5: With mode 3 (concatenated mode), the slot takes address bits from bit 2 upward in its low IDX_W-IDX_W/2 bits. Its upper IDX_W/2 bits hold the lowest history bits.
- R6: With CTR_W=1, an update writes the resolved outcome into the entry, and the prediction is that bit.
- R7: With CTR_W>=2, each entry is a saturating counter. Taken increments it below the all-ones value, not-taken decrements it above zero, and the prediction is its top bit.
- R8: Each update shifts its outcome into history bit 0 and moves older outcomes up. Cycles without an update leave the history unchanged. The update slot uses the history value from before that shift.
- R9: The lookup and update ports work independently in the same cycle. A lookup of the slot being written returns the old value, and the new value is seen from the next cycle on.
- R10: Reset clears the history to zero and sets every entry to not-taken: 0 for one-bit entries, and the value just below the midpoint (01 for two bits) for counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Index function select (0 address, 1 history, 2 hashed, 3 concatenated) |
| lk_addr_i | input | ADDR_W | Address of the branch being fetched |
| lk_taken_o | output | 1 | Predicted direction for lk_addr_i, 1 = taken |
| up_valid_i | input | 1 | A resolved branch is presented this cycle |
| up_addr_i | input | ADDR_W | Address of the resolved branch |
| up_taken_i | input | 1 | Resolved direction, 1 = taken |

## Verification
A prediction is due in the cycle its address is presented, with no register in the path. The bench therefore drives on the falling edge and compares shortly after, before the next rising edge. An update only becomes visible one rising edge later, in both the table and the history. The reference model applies each update to its own table and history after that edge, so every comparison in the same cycle sees the old values. This covers the case where the lookup and the update hit the same slot. Counter saturation and aliasing get directed sequences, and each index mode is then exercised with random traffic, comparing every cycle.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  typedef enum logic [1:0] {
    IDX_ADDR   = 2'd0,
    IDX_HIST   = 2'd1,
    IDX_HASH   = 2'd2,
    IDX_CONCAT = 2'd3
  } idx_mode_e;
endpackage

// File: rtl/bp_index.sv
module bp_index
  import bpred_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  idx_mode_e          mode,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [IDX_W-1:0]   hist,
  output logic [IDX_W-1:0]   idx
);
  localparam int HIST_BITS = IDX_W / 2;
  localparam int ADDR_BITS = IDX_W - HIST_BITS;

  function automatic logic [IDX_W-1:0] concat_idx(input logic [IDX_W-1:0] a,
                                                  input logic [IDX_W-1:0] h);
    logic [IDX_W-1:0] r;
    for (int i = 0; i < IDX_W; i++) begin
      if (i < ADDR_BITS) r[i] = a[i];
      else               r[i] = h[i-ADDR_BITS];
    end
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] form_index(input idx_mode_e m,
                                                  input logic [IDX_W-1:0] a,
                                                  input logic [IDX_W-1:0] h);
    case (m)
      IDX_ADDR: return a;
      IDX_HIST: return h;
      IDX_HASH: return a ^ h;
      default:  return concat_idx(a, h);
    endcase
  endfunction

  logic [IDX_W-1:0] addr_bits;
  assign addr_bits = addr[2 +: IDX_W];
  assign idx       = form_index(mode, addr_bits, hist);
endmodule

// File: rtl/bp_history.sv
module bp_history #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [IDX_W-1:0] hist_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)        hist_o <= '0;
    else if (shift_en) hist_o <= {hist_o[IDX_W-2:0], bit_in};
  end
endmodule

// File: rtl/bp_table.sv
module bp_table #(
  parameter int IDX_W = 6,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_entry,
  output logic             rd_pred,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  output logic [CTR_W-1:0] wr_old,
  output logic [CTR_W-1:0] wr_new
);
  localparam int          DEPTH   = 1 << IDX_W;
  localparam logic [CTR_W-1:0] TOP  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] INIT = (CTR_W == 1) ? '0 : CTR_W'((1 << (CTR_W-1)) - 1);

  logic [CTR_W-1:0] mem [DEPTH];

  function automatic logic [CTR_W-1:0] sat_step(input logic [CTR_W-1:0] c,
                                                input logic up);
    if (up)  return (c == TOP)  ? c : c + 1'b1;
    else     return (c == '0)   ? c : c - 1'b1;
  endfunction

  assign rd_entry = mem[rd_idx];
  assign rd_pred  = rd_entry[CTR_W-1];
  assign wr_old   = mem[wr_idx];

  generate
    if (CTR_W == 1) begin : g_last_bit
      assign wr_new = wr_taken;
    end else begin : g_counter
      assign wr_new = sat_step(wr_old, wr_taken);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_new;
    end
  end
endmodule

// File: rtl/bpred_top.sv
module bpred_top
  import bpred_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int CTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_taken_o,
  input  logic              up_valid_i,
  input  logic [ADDR_W-1:0] up_addr_i,
  input  logic              up_taken_i
);
  idx_mode_e        mode;
  logic [IDX_W-1:0] hist;
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] up_idx;
  logic [CTR_W-1:0] lk_entry;
  logic [CTR_W-1:0] up_old;
  logic [CTR_W-1:0] wr_val;

  assign mode = idx_mode_e'(mode_i);

  bp_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lk_index (
    .mode(mode), .addr(lk_addr_i), .hist(hist), .idx(lk_idx)
  );

  bp_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_up_index (
    .mode(mode), .addr(up_addr_i), .hist(hist), .idx(up_idx)
  );

  bp_history #(.IDX_W(IDX_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(up_valid_i), .bit_in(up_taken_i), .hist_o(hist)
  );

  bp_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_entry(lk_entry), .rd_pred(lk_taken_o),
    .wr_en(up_valid_i), .wr_idx(up_idx), .wr_taken(up_taken_i),
    .wr_old(up_old), .wr_new(wr_val)
  );
endmodule

// File: rtl/bpred_checker.sv
module bpred_checker #(
  parameter int IDX_W = 6,
  parameter int CTR_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             up_valid,
  input logic             up_taken,
  input logic [IDX_W-1:0] hist,
  input logic [IDX_W-1:0] lk_idx,
  input logic [IDX_W-1:0] up_idx,
  input logic [CTR_W-1:0] lk_entry,
  input logic [CTR_W-1:0] up_old,
  input logic [CTR_W-1:0] wr_val
);
  p_hist_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> hist == {$past(hist[IDX_W-2:0]), $past(up_taken)});

  p_hist_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(hist));

  p_wr_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(up_valid) && lk_idx == $past(up_idx)) |-> lk_entry == $past(wr_val));

  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> (wr_val == up_old) || (wr_val == CTR_W'(up_old + 1'b1))
                 || (wr_val == CTR_W'(up_old - 1'b1)));
endmodule

bind bpred_top bpred_checker #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_valid(up_valid_i), .up_taken(up_taken_i),
  .hist(hist), .lk_idx(lk_idx), .up_idx(up_idx), .lk_entry(lk_entry),
  .up_old(up_old), .wr_val(wr_val)
);

// File: tb/test_bpred_top.sv
module test_bpred_top;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 6;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int HB     = IDX_W / 2;
  localparam int AB     = IDX_W - HB;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        mode = 2'd0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic              up_valid = 1'b0;
  logic [ADDR_W-1:0] up_addr = '0;
  logic              up_taken = 1'b0;
  logic              pred2, pred1;

  int total = 0;
  int bad   = 0;
  int t2 [DEPTH];
  int t1 [DEPTH];
  int h = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bpred_top #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CTR_W(2)) i_bpred_top (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .lk_addr_i(lk_addr), .lk_taken_o(pred2),
    .up_valid_i(up_valid), .up_addr_i(up_addr), .up_taken_i(up_taken)
  );

  bpred_top #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CTR_W(1)) i_bpred_top_b (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .lk_addr_i(lk_addr), .lk_taken_o(pred1),
    .up_valid_i(up_valid), .up_addr_i(up_addr), .up_taken_i(up_taken)
  );

  function automatic int midx(int m, logic [ADDR_W-1:0] addr, int hh);
    int a;
    a = int'(addr >> 2) & (DEPTH - 1);
    case (m)
      0: return a;
      1: return hh;
      2: return hh ^ a;
      default: return ((hh & ((1 << HB) - 1)) << AB) | (a & ((1 << AB) - 1));
    endcase
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(string req, int m, logic [ADDR_W-1:0] la,
                      logic uv, logic [ADDR_W-1:0] ua, logic ut);
    int i;
    @(negedge clk);
    mode = m[1:0]; lk_addr = la; up_valid = uv; up_addr = ua; up_taken = ut;
    #1;
    i = midx(m, la, h);
    chk(req, "counter", pred2, t2[i] >= 2);
    chk(req, "onebit", pred1, t1[i] != 0);
    @(posedge clk);
    if (uv) begin
      i = midx(m, ua, h);
      if (ut && t2[i] < 3) t2[i]++;
      if (!ut && t2[i] > 0) t2[i]--;
      t1[i] = ut ? 1 : 0;
      h = ((h << 1) | (ut ? 1 : 0)) & (DEPTH - 1);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin t2[i] = 1; t1[i] = 0; end
    h = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R10: after reset every slot predicts not-taken in every mode
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 8; k++) step("R10", m, 32'(k * 36), 1'b0, '0, 1'b0);

    // R2 aliasing, R6 / R7 training in address mode
    step("R6", 0, 32'h40, 1'b1, 32'h40, 1'b1);
    step("R2", 0, 32'h40 + 32'(1 << (IDX_W + 2)), 1'b0, '0, 1'b0);
    // R7 saturation: many taken then one not-taken
    for (int k = 0; k < 5; k++) step("R7", 0, 32'h80, 1'b1, 32'h80, 1'b1);
    step("R7", 0, 32'h80, 1'b1, 32'h80, 1'b0);
    step("R7", 0, 32'h80, 1'b0, '0, 1'b0);
    step("R6", 0, 32'h80, 1'b1, 32'h80, 1'b1);
    // R9: same-slot lookup during a change sees the old value
    step("R9", 0, 32'h100, 1'b1, 32'h100, 1'b1);
    step("R9", 0, 32'h100, 1'b1, 32'h100, 1'b0);
    step("R9", 0, 32'h100, 1'b0, '0, 1'b0);

    // R3 / R8: history-only mode, address must not matter
    for (int k = 0; k < 40; k++)
      step("R8", 1, $urandom, 1'b1, $urandom, (k % 3) != 0);
    for (int k = 0; k < 20; k++)
      step("R3", 1, $urandom, 1'b0, '0, 1'b0);

    // Random traffic per mode (R1..R5)
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 400; k++)
        step(m == 0 ? "R2" : m == 1 ? "R3" : m == 2 ? "R4" : "R5", m,
             32'($urandom_range(0, 1023)) << 2, 1'($urandom),
             32'($urandom_range(0, 1023)) << 2, 1'($urandom_range(0, 3) != 0));

    // R1: dense sweep of every slot in address mode
    for (int k = 0; k < DEPTH; k++) step("R1", 0, 32'(k << 2), 1'b0, '0, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule